// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one character, taken through a valid/ready handshake, into an asynchronous serial frame on a single output line. The line rests high. A frame is a low start bit, then 5 to 9 data bits in the selected order, then an optional parity bit, then a high stop period of one, one and a half or two bits. Timing comes from an external baud generator. It delivers a one-cycle `bit_tick` pulse at twice the bit rate, so every bit lasts two ticks and a one-and-a-half stop period lasts three.

All configuration inputs are read together with the character, in the clock cycle of the handshake. A frame already on the line is therefore never changed by later configuration writes. A character offered while a frame is in flight simply waits until `in_ready` returns.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx` is 1, `busy` is 0 and `in_ready` is 1, and with `in_valid` low the line stays high whatever `bit_tick` does.
- R2: A handshake (`in_valid` and `in_ready` both 1 at a rising edge) makes `busy` 1, `in_ready` 0 and `tx` 0 (the start bit) from the next cycle. Every bit of the frame lasts exactly two ticks. `tx` changes only in the cycle after an edge at which `bit_tick` was 1.
- R3: The data length is 5 + `cfg_size` bits (size code 0→5, 1→6, 2→7, 3→8). When `cfg_nine` is 1 the length is 9 bits whatever `cfg_size` holds.
- R4: With `cfg_msb_first` = 0 the data bits go out from `in_data[0]` upward. With 1 they go out from `in_data[N-1]` downward, where N is the data length.
- R5: Parity code on `cfg_parity`: 0 even, 1 odd, 2 bit forced to 0, 3 bit forced to 1, 4 no parity bit. Codes 5 to 7 also send no parity bit. When present, the parity bit directly follows the last data bit.
- R6: Even and odd parity count only the N data bits that are sent. Bits of `in_data` above N affect neither the data nor the parity on the line.
- R7: Stop code on `cfg_stop`: 0 gives a high stop period of 2 ticks, 1 gives 3 ticks, 2 gives 4 ticks, and 3 behaves as 0. `busy` falls and `in_ready` rises in the cycle after the edge that samples the last stop tick.
- R8: With `cfg_invert` = 1 every data bit and the parity bit are sent inverted (parity is computed on the uninverted data). The start bit and stop bits are not inverted.
- R9: Configuration and data are captured at the handshake edge. Changes to any `cfg_*` input or to `in_data` during a frame do not alter it. A character held valid while `busy` is 1 is accepted only at the first edge after `in_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_parity | input | 3 | Parity code (R5) |
| cfg_size | input | 2 | Character size code (R3) |
| cfg_nine | input | 1 | Force 9-bit characters |
| cfg_stop | input | 2 | Stop period code (R7) |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_invert | input | 1 | Invert data and parity bits on the line |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 9 | Character, right aligned |
| bit_tick | input | 1 | One-cycle pulse at twice the bit rate |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The start bit and the raised `busy` are due one cycle after the handshake edge. Each later line change is due one cycle after an edge at which `bit_tick` was high. `in_ready` comes back one cycle after the edge carrying the last stop tick. The bench keeps to this by stepping a behavioural model at every rising edge, on the same inputs the design sees. The model holds a queue of expected half-bit line values, one entry removed per tick. The bench compares `tx`, `busy` and `in_ready` with the model at every falling edge, so each result is checked in the cycle it is due and in every cycle after.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int SFT_SIZE_BASE = 5;
    localparam int SFT_MAX_DATA  = 9;
    localparam int SFT_DLEN_W    = $clog2(SFT_MAX_DATA + 1);
    localparam int SFT_FRAME_W   = SFT_MAX_DATA + 4;
    localparam int SFT_HALF_MAX  = 2 * SFT_FRAME_W;
    localparam int SFT_HALF_W    = $clog2(SFT_HALF_MAX + 1);

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_ZERO = 3'd2,
        PAR_ONE  = 3'd3,
        PAR_NONE = 3'd4
    } parity_e;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,
        STOP_TWO  = 2'd2
    } stop_e;

    typedef struct packed {
        logic                    busy;
        logic                    phase;
        logic [SFT_HALF_W-1:0]   left;
        logic [SFT_FRAME_W-1:0]  shreg;
    } seq_state_t;

endpackage

// File: rtl/sft_frame_builder.sv
module sft_frame_builder
    import sft_pkg::*;
(
    input  logic [2:0]              cfg_parity,
    input  logic [1:0]              cfg_size,
    input  logic                    cfg_nine,
    input  logic [1:0]              cfg_stop,
    input  logic                    cfg_msb_first,
    input  logic                    cfg_invert,
    input  logic [SFT_MAX_DATA-1:0] in_data,
    output logic [SFT_FRAME_W-1:0]  frame_bits,
    output logic [SFT_HALF_W-1:0]   frame_halves
);

    logic [SFT_DLEN_W-1:0]   data_len;
    logic [SFT_MAX_DATA-1:0] ordered;
    logic [SFT_DLEN_W-1:0]   src_idx;
    logic                    ones_odd;
    logic                    par_bit;
    logic                    has_par;
    logic [2:0]              stop_halves;

    always_comb begin
        data_len = cfg_nine ? SFT_DLEN_W'(SFT_MAX_DATA)
                            : SFT_DLEN_W'(SFT_SIZE_BASE + int'(cfg_size));
        ordered  = '0;
        ones_odd = 1'b0;
        src_idx  = '0;
        for (int i = 0; i < SFT_MAX_DATA; i++) begin
            if (i < int'(data_len)) begin
                ones_odd = ones_odd ^ in_data[i];
                src_idx  = cfg_msb_first ? SFT_DLEN_W'(int'(data_len) - 1 - i)
                                         : SFT_DLEN_W'(i);
                ordered[i] = in_data[src_idx];
            end
        end
    end

    always_comb begin
        has_par = 1'b1;
        case (parity_e'(cfg_parity))
            PAR_EVEN: par_bit = ones_odd;
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_ZERO: par_bit = 1'b0;
            PAR_ONE:  par_bit = 1'b1;
            default: begin
                par_bit = 1'b1;
                has_par = 1'b0;
            end
        endcase
    end

    always_comb begin
        case (stop_e'(cfg_stop))
            STOP_HALF: stop_halves = 3'd3;
            STOP_TWO:  stop_halves = 3'd4;
            default:   stop_halves = 3'd2;
        endcase
    end

    always_comb begin
        frame_bits    = '1;
        frame_bits[0] = 1'b0;
        for (int i = 0; i < SFT_MAX_DATA; i++) begin
            if (i < int'(data_len)) begin
                frame_bits[i + 1] = ordered[i] ^ cfg_invert;
            end
        end
        for (int k = SFT_SIZE_BASE; k <= SFT_MAX_DATA; k++) begin
            if (has_par && (k == int'(data_len))) begin
                frame_bits[k + 1] = par_bit ^ cfg_invert;
            end
        end
        frame_halves = SFT_HALF_W'(2 * (1 + int'(data_len) + int'(has_par))
                                   + int'(stop_halves));
    end

endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   bit_tick,
    input  logic [SFT_FRAME_W-1:0] frame_bits,
    input  logic [SFT_HALF_W-1:0]  frame_halves,
    output logic                   in_ready,
    output logic                   tx,
    output logic                   busy
);

    seq_state_t state_d;
    seq_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (in_valid) begin
                state_d.busy  = 1'b1;
                state_d.phase = 1'b0;
                state_d.left  = frame_halves;
                state_d.shreg = frame_bits;
            end
        end else if (bit_tick) begin
            state_d.left  = state_q.left - 1'b1;
            state_d.phase = ~state_q.phase;
            if (state_q.phase) begin
                state_d.shreg = {1'b1, state_q.shreg[SFT_FRAME_W-1:1]};
            end
            if (state_q.left == SFT_HALF_W'(1)) begin
                state_d.busy  = 1'b0;
                state_d.shreg = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{busy: 1'b0, phase: 1'b0, left: '0, shreg: '1};
        end else begin
            state_q <= state_d;
        end
    end

    assign in_ready = ~state_q.busy;
    assign busy     = state_q.busy;
    assign tx       = state_q.shreg[0];

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cfg_parity,
    input  logic [1:0]              cfg_size,
    input  logic                    cfg_nine,
    input  logic [1:0]              cfg_stop,
    input  logic                    cfg_msb_first,
    input  logic                    cfg_invert,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [SFT_MAX_DATA-1:0] in_data,
    input  logic                    bit_tick,
    output logic                    tx,
    output logic                    busy
);

    logic [SFT_FRAME_W-1:0] frame_bits;
    logic [SFT_HALF_W-1:0]  frame_halves;

    sft_frame_builder u_builder (
        .cfg_parity    (cfg_parity),
        .cfg_size      (cfg_size),
        .cfg_nine      (cfg_nine),
        .cfg_stop      (cfg_stop),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .in_data       (in_data),
        .frame_bits    (frame_bits),
        .frame_halves  (frame_halves)
    );

    sft_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .bit_tick     (bit_tick),
        .frame_bits   (frame_bits),
        .frame_halves (frame_halves),
        .in_ready     (in_ready),
        .tx           (tx),
        .busy         (busy)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic bit_tick,
    input logic tx,
    input logic busy
);

    // R1: an idle line with nothing offered stays idle and high
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !in_valid) |=> (!busy && tx));

    // R2: a handshake starts the frame with a low start bit
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !tx && !in_ready));

    // R2: the line moves only on ticks while a frame runs
    a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(tx));

    // R7: the frame can only end on a tick
    a_r7_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    // R9: without a tick a running frame is neither ended nor restarted
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> (busy && !in_ready));

endmodule

bind serial_frame_tx sft_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bit_tick (bit_tick),
    .tx       (tx),
    .busy     (busy)
);

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_parity = 3'd4;
    logic [1:0] cfg_size = 2'd3;
    logic       cfg_nine = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = 9'd0;
    logic       bit_tick = 1'b0;
    logic       tx;
    logic       busy;

    int    n_checks = 0;
    int    n_fail = 0;
    int    tick_div = 3;
    int    cycles = 0;
    bit    running = 1'b0;
    string cur_req = "R1";

    bit m_busy = 1'b0;
    bit m_line[$];
    int m_kind[$];

    serial_frame_tx u_serial_frame_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_parity    (cfg_parity),
        .cfg_size      (cfg_size),
        .cfg_nine      (cfg_nine),
        .cfg_stop      (cfg_stop),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .bit_tick      (bit_tick),
        .tx            (tx),
        .busy          (busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string kind_name(int k);
        case (k)
            0: return "R2 start";
            1: return "R4 data";
            2: return "R5 parity";
            default: return "R7 stop";
        endcase
    endfunction

    // behavioural frame expansion, one queue entry per half-bit
    task automatic model_load();
        int n;
        int ones;
        int stop_h;
        bit b;
        bit p;
        bit has_p;
        n = cfg_nine ? 9 : 5 + int'(cfg_size);
        ones = 0;
        m_line.delete();
        m_kind.delete();
        repeat (2) begin m_line.push_back(1'b0); m_kind.push_back(0); end
        for (int i = 0; i < n; i++) begin
            b = cfg_msb_first ? in_data[n - 1 - i] : in_data[i];
            ones += int'(in_data[i]);
            repeat (2) begin m_line.push_back(b ^ cfg_invert); m_kind.push_back(1); end
        end
        has_p = 1'b1;
        case (cfg_parity)
            3'd0: p = (ones % 2) == 1;
            3'd1: p = (ones % 2) == 0;
            3'd2: p = 1'b0;
            3'd3: p = 1'b1;
            default: begin p = 1'b1; has_p = 1'b0; end
        endcase
        if (has_p) begin
            repeat (2) begin m_line.push_back(p ^ cfg_invert); m_kind.push_back(2); end
        end
        stop_h = (cfg_stop == 2'd1) ? 3 : (cfg_stop == 2'd2) ? 4 : 2;
        repeat (stop_h) begin m_line.push_back(1'b1); m_kind.push_back(3); end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_busy = 1'b0;
                m_line.delete();
                m_kind.delete();
            end else if (!m_busy) begin
                if (in_valid) begin
                    model_load();
                    m_busy = 1'b1;
                end
            end else if (bit_tick) begin
                void'(m_line.pop_front());
                void'(m_kind.pop_front());
                if (m_line.size() == 0) m_busy = 1'b0;
            end
        end
    end

    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            bit_tick = (tick_div <= 1) ? 1'b1 : ((cnt % tick_div) == 0);
        end
    end

    initial begin
        bit e_tx;
        string tag;
        forever begin
            @(negedge clk);
            #1;
            if (running && rst_n) begin
                e_tx = m_busy ? m_line[0] : 1'b1;
                tag  = m_busy ? kind_name(m_kind[0]) : "R1 idle";
                n_checks++;
                if (tx !== e_tx || busy !== m_busy || in_ready !== !m_busy) begin
                    n_fail++;
                    $display("FAIL %s [%s] t=%0t tx/busy/ready actual %b%b%b expected %b%b%b",
                             cur_req, tag, $time, tx, busy, in_ready,
                             e_tx, m_busy, !m_busy);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 watchdog actual %0d cycles expected at most %0d",
                         cycles, WATCHDOG);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    task automatic set_cfg(input logic [2:0] par, input logic [1:0] sz, input logic nine,
                           input logic [1:0] stp, input logic msb, input logic inv);
        cfg_parity = par; cfg_size = sz; cfg_nine = nine;
        cfg_stop = stp; cfg_msb_first = msb; cfg_invert = inv;
    endtask

    task automatic send(input logic [8:0] d);
        bit seen;
        in_data = d;
        in_valid = 1'b1;
        forever begin
            seen = in_ready;
            @(negedge clk);
            if (seen) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame(input logic [8:0] d);
        send(d);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        n_checks++;
        if (tx !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset tx/busy/ready actual %b%b%b expected 101",
                     tx, busy, in_ready);
        end
        rst_n = 1'b1;
        running = 1'b1;
        repeat (20) @(negedge clk);

        cur_req = "R3";
        set_cfg(3'd4, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
        frame(9'h0A5);
        frame(9'h03C);
        for (int s = 0; s < 4; s++) begin
            set_cfg(3'd4, 2'(s), 1'b0, 2'd0, 1'b0, 1'b0);
            frame(9'h1B3);
        end
        set_cfg(3'd4, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        frame(9'h155);
        frame(9'h100);

        cur_req = "R4";
        set_cfg(3'd4, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0);
        frame(9'h0C1);
        set_cfg(3'd4, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0);
        frame(9'h02D);
        set_cfg(3'd4, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0);
        frame(9'h10E);

        cur_req = "R5";
        for (int p = 0; p < 8; p++) begin
            set_cfg(3'(p), 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
            frame(9'h0B7);
            frame(9'h0B6);
        end

        cur_req = "R6";
        set_cfg(3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        frame(9'h1E1);
        set_cfg(3'd1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0);
        frame(9'h1C3);

        cur_req = "R7";
        for (int s = 0; s < 4; s++) begin
            set_cfg(3'd1, 2'd3, 1'b0, 2'(s), 1'b0, 1'b0);
            frame(9'h05A);
        end
        tick_div = 1;
        set_cfg(3'd4, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        frame(9'h013);
        tick_div = 3;

        cur_req = "R8";
        set_cfg(3'd2, 2'd3, 1'b0, 2'd2, 1'b0, 1'b1);
        frame(9'h0F0);
        set_cfg(3'd0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1);
        frame(9'h0A7);

        cur_req = "R9";
        set_cfg(3'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
        send(9'h081);
        repeat (7) @(negedge clk);
        set_cfg(3'd3, 2'd0, 1'b1, 2'd2, 1'b1, 1'b1);
        in_data = 9'h17E;
        in_valid = 1'b1;
        repeat (5) @(negedge clk);
        cfg_size = 2'd1;
        send(9'h133);
        wait_idle();
        tick_div = 2;
        send(9'h055);
        send(9'h0AA);
        wait_idle();

        cur_req = "R1";
        repeat (30) @(negedge clk);
        running = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule